// File: doc/BRIEF.md
# Stereo Static-Data Auto-Mute Detector

This block sits after a serial audio receiver and watches the stream of stereo sample pairs it delivers. Each pair arrives with a one-cycle valid strobe. The block counts consecutive pairs in which both channels carry static data. It raises the mute for both channels once that run reaches a fixed length of 8192 pairs. The first pair with non-static content drops the mute again. Static data means a word of all zeros or all ones.

An active-low enable gates the automatic mute. Each channel also has an active-low manual mute input, and that input acts on its own channel only. The two registered mute outputs drive the downstream muting stage. Each output is the OR of the shared automatic mute and that channel's manual request.

Top module: `stereo_automute`

## Requirements
- R1: While `rst` is high, and on the first edge after it, both `mute_left` and `mute_right` are low and the run count is zero.
- R2: With the enable low and both manual inputs high, both mute outputs go high on the clock edge that accepts the 8192nd consecutive qualifying pair. After 8191 such pairs they are still low.
- R3: A valid pair in which either channel is neither all zeros nor all ones drops the automatic mute on the edge that accepts it.
- R4: A channel qualifies as static if its word is all zeros or all ones, judged separately for each channel. A run in which left is all ones and right is all zeros counts exactly like an all-zero run.
- R5: After a non-static pair, including one where only one channel is non-static, a fresh run of 8192 qualifying pairs is needed before the mute engages again.
- R6: Cycles with `pair_valid` low neither advance nor clear the run, whatever the sample inputs carry.
- R7: While `auto_en_n` is high, no automatic mute reaches the outputs, however long the static run lasts.
- R8: The run count saturates at the threshold. Further static pairs keep the mute asserted. If `auto_en_n` falls while the count is saturated, the mute outputs rise on the next edge.
- R9: `mute_left_n` low sets `mute_left` on the next edge, and `mute_right_n` low does the same for `mute_right`. Neither affects the other channel.
- R10: Each output is the OR of the automatic mute and its manual mute. Releasing a manual input does not clear an active automatic mute, and releasing the automatic mute does not clear an active manual mute.
- R11: A pulse on `rst` in the middle of a run clears the run, so the next mute needs a full 8192 qualifying pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_valid | input | 1 | One-cycle strobe: a new stereo pair is present |
| left_sample | input | SAMPLE_W | Left channel word, two's complement |
| right_sample | input | SAMPLE_W | Right channel word, two's complement |
| auto_en_n | input | 1 | Active-low enable for the automatic mute |
| mute_left_n | input | 1 | Active-low manual mute, left channel |
| mute_right_n | input | 1 | Active-low manual mute, right channel |
| mute_left | output | 1 | Registered mute control, left channel |
| mute_right | output | 1 | Registered mute control, right channel |

## Verification
The hardest state to reach from the ports is the exact threshold edge after a long run. The run must be built from a mix of static kinds and be interrupted by idle strobes, and a non-static pair or a reset must arrive partway through. Directed phases feed 8191 pairs and then one more, insert garbage on cycles with the strobe low, and restart runs after a single-channel disturbance and after a reset. A seeded random phase mixes static words, arbitrary words, strobe gaps and manual toggles. A bench model built from the requirements checks the outputs on every cycle.

// File: rtl/amute_pkg.sv
package amute_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    LVL_ZERO  = 2'd0,
    LVL_ONE   = 2'd1,
    LVL_MIXED = 2'd2
  } level_t;
endpackage

// File: rtl/amute_level_class.sv
module amute_level_class #(
  parameter int SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] word,
  output logic                is_static
);
  import amute_pkg::*;

  level_t level;

  always_comb begin
    if (word == '0)      level = LVL_ZERO;
    else if (word == '1) level = LVL_ONE;
    else                 level = LVL_MIXED;
    is_static = (level != LVL_MIXED);
  end
endmodule

// File: rtl/amute_run_counter.sv
module amute_run_counter #(
  parameter int RUN_FRAMES = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_valid,
  input  logic frame_static,
  output logic run_full_nxt
);
  localparam int CW = $clog2(RUN_FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_FRAMES);

  logic [CW-1:0] run_cnt;
  logic [CW-1:0] run_cnt_nxt;

  always_comb begin
    run_cnt_nxt = run_cnt;
    if (frame_valid) begin
      if (!frame_static)         run_cnt_nxt = '0;
      else if (run_cnt != LIMIT) run_cnt_nxt = run_cnt + 1'b1;
    end
    run_full_nxt = (run_cnt_nxt == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else     run_cnt <= run_cnt_nxt;
  end
endmodule

// File: rtl/amute_out_stage.sv
module amute_out_stage #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           auto_hit,
  input  logic           auto_en_n,
  input  logic [NCH-1:0] manual_n,
  output logic [NCH-1:0] mute
);
  logic auto_mute;
  assign auto_mute = auto_hit && !auto_en_n;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) mute[c] <= 1'b0;
      else     mute[c] <= auto_mute || !manual_n[c];
    end
  end
endmodule

// File: rtl/stereo_automute.sv
module stereo_automute #(
  parameter int SAMPLE_W   = 20,
  parameter int RUN_FRAMES = 8192
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pair_valid,
  input  logic [SAMPLE_W-1:0] left_sample,
  input  logic [SAMPLE_W-1:0] right_sample,
  input  logic                auto_en_n,
  input  logic                mute_left_n,
  input  logic                mute_right_n,
  output logic                mute_left,
  output logic                mute_right
);
  import amute_pkg::*;

  logic [SAMPLE_W-1:0] ch_word [NUM_CH];
  logic [NUM_CH-1:0]   ch_static;
  logic [NUM_CH-1:0]   man_n;
  logic [NUM_CH-1:0]   mute_vec;
  logic                run_full_nxt;

  assign ch_word[0] = left_sample;
  assign ch_word[1] = right_sample;
  assign man_n      = {mute_right_n, mute_left_n};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_class
    amute_level_class #(.SAMPLE_W(SAMPLE_W)) u_class (
      .word      (ch_word[c]),
      .is_static (ch_static[c])
    );
  end

  amute_run_counter #(.RUN_FRAMES(RUN_FRAMES)) u_run (
    .clk          (clk),
    .rst          (rst),
    .frame_valid  (pair_valid),
    .frame_static (&ch_static),
    .run_full_nxt (run_full_nxt)
  );

  amute_out_stage #(.NCH(NUM_CH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .auto_hit  (run_full_nxt),
    .auto_en_n (auto_en_n),
    .manual_n  (man_n),
    .mute      (mute_vec)
  );

  assign mute_left  = mute_vec[0];
  assign mute_right = mute_vec[1];
endmodule

// File: rtl/stereo_automute_chk.sv
module stereo_automute_chk #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                pair_valid,
  input logic [SAMPLE_W-1:0] left_sample,
  input logic [SAMPLE_W-1:0] right_sample,
  input logic                auto_en_n,
  input logic                mute_left_n,
  input logic                mute_right_n,
  input logic                mute_left,
  input logic                mute_right
);
  logic busy_pair;
  assign busy_pair = pair_valid &&
    ((left_sample != '0 && left_sample != '1) ||
     (right_sample != '0 && right_sample != '1));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (rst)
    busy_pair && mute_left_n && mute_right_n |=> !mute_left && !mute_right);

  // R9
  manual_left_chk: assert property (@(posedge clk) disable iff (rst)
    !mute_left_n |=> mute_left);

  // R9
  manual_right_chk: assert property (@(posedge clk) disable iff (rst)
    !mute_right_n |=> mute_right);

  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    auto_en_n && mute_left_n && mute_right_n |=> !mute_left && !mute_right);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pair_valid && $stable(auto_en_n) && $stable(mute_left_n) && $stable(mute_right_n)
    |=> mute_left == $past(mute_left) && mute_right == $past(mute_right));

  // R10
  shared_auto_chk: assert property (@(posedge clk) disable iff (rst)
    mute_left_n && mute_right_n |=> mute_left == mute_right);
endmodule

bind stereo_automute stereo_automute_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pair_valid   (pair_valid),
  .left_sample  (left_sample),
  .right_sample (right_sample),
  .auto_en_n    (auto_en_n),
  .mute_left_n  (mute_left_n),
  .mute_right_n (mute_right_n),
  .mute_left    (mute_left),
  .mute_right   (mute_right)
);

// File: tb/stereo_automute_test.sv
module stereo_automute_test;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 20;
  localparam int THR = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pv = 1'b0;
  logic [W-1:0] ls = '0, rs = '0;
  logic en_n = 1'b0, ml_n = 1'b1, mr_n = 1'b1;
  logic mute_l, mute_r;

  int n_chk = 0, n_err = 0;
  string cur_tag = "R1";
  int mcnt = 0;
  logic el = 1'b0, er = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_automute #(.SAMPLE_W(W), .RUN_FRAMES(THR)) uut (
    .clk(clk), .rst(rst), .pair_valid(pv), .left_sample(ls), .right_sample(rs),
    .auto_en_n(en_n), .mute_left_n(ml_n), .mute_right_n(mr_n),
    .mute_left(mute_l), .mute_right(mute_r));

  function automatic bit is_stat(logic [W-1:0] v);
    return (v == '0) || (v == '1);
  endfunction

  function automatic int next_count(int c, logic v, logic [W-1:0] a, logic [W-1:0] b);
    if (!v) return c;
    if (!(is_stat(a) && is_stat(b))) return 0;
    return (c >= THR) ? THR : c + 1;
  endfunction

  // Reference model from the requirements
  always @(posedge clk) begin
    int n;
    if (rst) begin
      mcnt = 0; el = 1'b0; er = 1'b0;
    end else begin
      n = next_count(mcnt, pv, ls, rs);
      el = ((n == THR) && !en_n) || !ml_n;
      er = ((n == THR) && !en_n) || !mr_n;
      mcnt = n;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk({cur_tag, " model left"}, mute_l, el);
    chk({cur_tag, " model right"}, mute_r, er);
  end

  task automatic send(logic v, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    pv = v; ls = a; rs = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run(int n, logic [W-1:0] a, logic [W-1:0] b);
    for (int i = 0; i < n; i++) send(1'b1, a, b);
  endtask

  task automatic both(string tag, logic exp);
    chk({tag, " left"}, mute_l, exp);
    chk({tag, " right"}, mute_r, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog R1..: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    both("R1 in reset", 1'b0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    both("R1 after reset", 1'b0);

    cur_tag = "R2";
    run(THR - 1, '0, '0);
    both("R2 after 8191", 1'b0);
    run(1, '0, '0);
    both("R2 at 8192", 1'b1);

    cur_tag = "R3";
    send(1'b1, 20'h00012, '0);
    both("R3 release", 1'b0);

    cur_tag = "R4";
    run(THR, '1, '0);
    both("R4 mixed static kinds", 1'b1);

    cur_tag = "R5";
    send(1'b1, '0, 20'h00005);
    both("R5 one-channel busy", 1'b0);
    run(THR - 1, '0, '1);
    both("R5 run restarted", 1'b0);

    cur_tag = "R6";
    for (int i = 0; i < 50; i++) send(1'b0, 20'h1234 + W'(i), 20'h0abcd);
    both("R6 idle garbage", 1'b0);
    run(1, '0, '0);
    both("R6 run resumed", 1'b1);

    cur_tag = "R8";
    run(100, '1, '1);
    both("R8 saturated hold", 1'b1);

    cur_tag = "R7";
    @(negedge clk); en_n = 1'b1;
    run(20, '0, '0);
    both("R7 disabled", 1'b0);
    cur_tag = "R8";
    @(negedge clk); en_n = 1'b0;
    @(posedge clk); #1;
    both("R8 re-enable", 1'b1);

    cur_tag = "R10";
    @(negedge clk); ml_n = 1'b0;
    send(1'b0, '0, '0);
    @(negedge clk); ml_n = 1'b1;
    send(1'b0, '0, '0);
    both("R10 manual release under auto", 1'b1);
    @(negedge clk); mr_n = 1'b0;
    send(1'b1, 20'h00777, 20'h00777);
    chk("R10 auto release keeps manual", mute_r, 1'b1);
    chk("R9 other channel free", mute_l, 1'b0);
    @(negedge clk); mr_n = 1'b1; ml_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 left manual", mute_l, 1'b1);
    chk("R9 right freed", mute_r, 1'b0);
    @(negedge clk); ml_n = 1'b1;
    @(posedge clk); #1;
    both("R9 released", 1'b0);

    cur_tag = "R11";
    run(8000, '0, '0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    run(200, '0, '0);
    both("R11 reset cleared run", 1'b0);
    run(THR - 200, '0, '0);
    both("R11 full run after reset", 1'b1);

    cur_tag = "R3 random";
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [W-1:0] a, b;
      k = int'($urandom_range(0, 19));
      a = (k == 0) ? W'($urandom) : ((k & 1) != 0 ? '1 : '0);
      b = (k == 1) ? W'($urandom) : ((k & 2) != 0 ? '1 : '0);
      @(negedge clk);
      pv = ($urandom_range(0, 3) != 0);
      ls = a; rs = b;
      ml_n = ($urandom_range(0, 15) != 0);
      mr_n = ($urandom_range(0, 15) != 0);
      en_n = ($urandom_range(0, 63) == 0);
    end
    @(negedge clk);
    pv = 1'b0; ml_n = 1'b1; mr_n = 1'b1; en_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule